// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept or thrown away. It looks only at the 48-bit destination address, which arrives one byte per clock on a byte stream marked by a byte-valid qualifier. A start strobe marks the first address byte of each frame. A frame-end input tells the filter that the frame stopped early. The receive path upstream feeds the first six bytes of every frame into the filter. The receive buffer downstream uses the decision to keep the frame or discard it internally.

The filter applies five rules:
- a switch that rejects or passes broadcast frames;
- an exact compare against the station's own unicast address;
- a 64-entry hash table for individual addresses that miss the exact compare;
- a second 64-entry hash table for group addresses;
- a promiscuous override that passes everything.

The hash index is taken from a CRC that is updated as each byte streams in. The decision arrives one clock after the sixth byte, together with a code that names the rule that decided.

Top module: `eth_da_filter`

## Requirements
- R1: When the sixth address byte is taken on a clock edge, `dec_valid` is high for exactly the following cycle. It is low at all other times.
- R2: Byte k of the frame (k = 0 first) is destination bit range [8k+7:8k]. Bit 0 of byte 0 is the group bit: 1 means group address, 0 means individual address. A group address that equals the station address in every other bit is treated as a group address, never as an exact match.
- R3: A destination of all ones is broadcast. It is accepted with match code 1 when `bcast_reject` is 0. It is rejected with match code 0 when `bcast_reject` is 1. Neither hash table is consulted for a broadcast destination.
- R4: An individual destination equal to `station_addr` in all 48 bits is accepted with match code 2.
- R5: The hash index comes from a CRC-32 with polynomial 0x04C11DB7. The register starts at all ones. The six bytes are fed bit 0 first, and there is no final inversion. The index is bits [31:26] of the register after the sixth byte. An individual destination that misses the exact compare is accepted with match code 3 when `uc_hash[index]` is 1.
- R6: A group destination that is not broadcast is accepted with match code 4 when `mc_hash[index]` is 1.
- R7: When `promisc_en` is 1, every frame is accepted, and the match code is 5 regardless of the address.
- R8: A frame that no rule accepts gives `dec_valid` = 1, `dec_accept` = 0 and match code 0. Whenever `dec_accept` is 1 with a decision, the match code is nonzero.
- R9: A start strobe with a byte restarts the byte count and the CRC, even in the middle of an address. The decision then reflects only the bytes from the latest start.
- R10: If `frm_end` arrives before the sixth byte, no decision is issued for that frame. Bytes that arrive after the sixth, without a new start strobe, produce no decision.
- R11: While `rst` is high, and in any cycle without a decision, `dec_valid`, `dec_accept` and `dec_match` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | `byte_in` carries an address byte this cycle |
| sof | input | 1 | With `byte_vld`: this byte is byte 0 of a new frame |
| byte_in | input | 8 | Address byte |
| frm_end | input | 1 | Frame ended; abandons an incomplete address |
| station_addr | input | 48 | Station unicast address, byte k in [8k+7:8k] |
| uc_hash | input | 64 | Individual-address hash table |
| mc_hash | input | 64 | Group-address hash table |
| bcast_reject | input | 1 | 1 rejects broadcast frames |
| promisc_en | input | 1 | 1 accepts every frame |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 keeps the frame, 0 discards it |
| dec_match | output | 3 | 0 none, 1 broadcast, 2 exact, 3 individual hash, 4 group hash, 5 promiscuous |

## Verification
The assertions check several properties on every cycle:
- the decision strobe is a single-cycle pulse that follows a taken byte;
- accept and match code agree;
- the outputs are quiet when there is no decision;
- promiscuous mode always reports code 5.

Only the bench's scenarios can show that the right rule fires for a given address. These include the CRC-derived hash index, the group-bit classification of a near-station address, and broadcast rejection. The same holds for the restart, early-end and trailing-byte cases, because they depend on the history of the byte stream.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
  typedef enum logic [2:0] {
    MT_NONE    = 3'd0,
    MT_BCAST   = 3'd1,
    MT_EXACT   = 3'd2,
    MT_UHASH   = 3'd3,
    MT_GHASH   = 3'd4,
    MT_PROMISC = 3'd5
  } match_t;

  // One serial CRC step per data bit, bit 0 first.
  function automatic logic [31:0] crc_byte_step(input logic [31:0] crc,
                                                input logic [7:0]  data,
                                                input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = crc;
    for (int b = 0; b < 8; b++) begin
      fb = c[31] ^ data[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/eth_crc_byte.sv
module eth_crc_byte #(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic [31:0] crc_in,
  input  logic [7:0]  data_in,
  output logic [31:0] crc_out
);
  import eth_filt_pkg::*;

  always_comb crc_out = crc_byte_step(crc_in, data_in, POLY);
endmodule

// File: rtl/eth_addr_track.sv
module eth_addr_track #(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] POLY       = 32'h04C11DB7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_vld,
  input  logic                    sof,
  input  logic [7:0]              byte_in,
  input  logic                    frm_end,
  output logic                    last_take,
  output logic [8*ADDR_BYTES-1:0] addr_full,
  output logic [HASH_BITS-1:0]    hash_idx
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int HOLD_W = ADDR_W - 8;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic [31:0]       crc_q;
  logic [31:0]       crc_base;
  logic [31:0]       crc_nx;
  logic              take;
  logic [CNT_W-1:0]  idx;

  assign take      = byte_vld && !frm_end && (sof || active_q);
  assign idx       = sof ? '0 : cnt_q;
  assign last_take = take && (idx == LAST_IDX);
  assign crc_base  = sof ? 32'hFFFF_FFFF : crc_q;
  assign addr_full = {byte_in, hold_q};
  assign hash_idx  = crc_nx[31 -: HASH_BITS];

  eth_crc_byte #(.POLY(POLY)) u_crc (
    .crc_in  (crc_base),
    .data_in (byte_in),
    .crc_out (crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      crc_q    <= 32'hFFFF_FFFF;
    end else if (take) begin
      active_q <= (idx != LAST_IDX);
      cnt_q    <= idx + 1'b1;
      crc_q    <= crc_nx;
    end else if (frm_end) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end
  end

  generate
    for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst) hold_q[8*k +: 8] <= '0;
        else if (take && idx == CNT_W'(k)) hold_q[8*k +: 8] <= byte_in;
      end
    end
  endgenerate
endmodule

// File: rtl/eth_addr_classify.sv
module eth_addr_classify #(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [HASH_BITS-1:0]      hash_idx,
  input  logic [ADDR_W-1:0]         station_addr,
  input  logic [(1<<HASH_BITS)-1:0] uc_hash,
  input  logic [(1<<HASH_BITS)-1:0] mc_hash,
  input  logic                      bcast_reject,
  input  logic                      promisc_en,
  output logic                      accept,
  output logic [2:0]                match
);
  import eth_filt_pkg::*;

  logic   is_bcast;
  logic   is_group;
  match_t m;

  assign is_bcast = &addr;
  assign is_group = addr[0];

  always_comb begin
    if (promisc_en)
      m = MT_PROMISC;
    else if (is_bcast)
      m = bcast_reject ? MT_NONE : MT_BCAST;
    else if (is_group)
      m = mc_hash[hash_idx] ? MT_GHASH : MT_NONE;
    else if (addr == station_addr)
      m = MT_EXACT;
    else
      m = uc_hash[hash_idx] ? MT_UHASH : MT_NONE;
  end

  assign match  = m;
  assign accept = (m != MT_NONE);
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] POLY       = 32'h04C11DB7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        byte_vld,
  input  logic                        sof,
  input  logic [7:0]                  byte_in,
  input  logic                        frm_end,
  input  logic [8*ADDR_BYTES-1:0]     station_addr,
  input  logic [(1<<HASH_BITS)-1:0]   uc_hash,
  input  logic [(1<<HASH_BITS)-1:0]   mc_hash,
  input  logic                        bcast_reject,
  input  logic                        promisc_en,
  output logic                        dec_valid,
  output logic                        dec_accept,
  output logic [2:0]                  dec_match
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic                 last_take;
  logic [ADDR_W-1:0]    addr_full;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 cls_accept;
  logic [2:0]           cls_match;

  eth_addr_track #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS),
    .POLY       (POLY)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .sof       (sof),
    .byte_in   (byte_in),
    .frm_end   (frm_end),
    .last_take (last_take),
    .addr_full (addr_full),
    .hash_idx  (hash_idx)
  );

  eth_addr_classify #(
    .ADDR_W    (ADDR_W),
    .HASH_BITS (HASH_BITS)
  ) u_cls (
    .addr         (addr_full),
    .hash_idx     (hash_idx),
    .station_addr (station_addr),
    .uc_hash      (uc_hash),
    .mc_hash      (mc_hash),
    .bcast_reject (bcast_reject),
    .promisc_en   (promisc_en),
    .accept       (cls_accept),
    .match        (cls_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_match  <= 3'd0;
    end else begin
      dec_valid  <= last_take;
      dec_accept <= last_take && cls_accept;
      dec_match  <= last_take ? cls_match : 3'd0;
    end
  end
endmodule

// File: rtl/eth_da_filter_chk.sv
module eth_da_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic       frm_end,
  input logic       promisc_en,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [2:0] dec_match
);
  // R1: a decision follows a byte that was taken
  a_r1_after_byte: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(byte_vld && !frm_end));

  // R1: the strobe lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R8: a rejection reports no rule
  a_r8_reject_none: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_accept) |-> dec_match == 3'd0);

  // R8: an acceptance names a rule
  a_r8_accept_rule: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_accept) |-> (dec_match != 3'd0 && dec_match <= 3'd5));

  // R7: promiscuous mode reports code 5
  a_r7_promisc: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(promisc_en)) |-> (dec_accept && dec_match == 3'd5));

  // R11: outputs are quiet without a decision
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && dec_match == 3'd0));
endmodule

bind eth_da_filter eth_da_filter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_vld   (byte_vld),
  .frm_end    (frm_end),
  .promisc_en (promisc_en),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_match  (dec_match)
);

// File: tb/eth_da_filter_bench.sv
module eth_da_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic        sof = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        frm_end = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] uc_hash = 64'h0;
  logic [63:0] mc_hash = 64'h0;
  logic        bcast_reject = 1'b0;
  logic        promisc_en = 1'b0;
  logic        dec_valid;
  logic        dec_accept;
  logic [2:0]  dec_match;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eth_da_filter u_eth_da_filter (
    .clk (clk), .rst (rst), .byte_vld (byte_vld), .sof (sof),
    .byte_in (byte_in), .frm_end (frm_end), .station_addr (station_addr),
    .uc_hash (uc_hash), .mc_hash (mc_hash), .bcast_reject (bcast_reject),
    .promisc_en (promisc_en), .dec_valid (dec_valid),
    .dec_accept (dec_accept), .dec_match (dec_match)
  );

  function automatic logic [31:0] crc_ref(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic logic [2:0] exp_match(input logic [47:0] a);
    logic [5:0] h = crc_ref(a)[31:26];
    if (promisc_en) return 3'd5;
    if (a == {48{1'b1}}) return bcast_reject ? 3'd0 : 3'd1;
    if (a[0]) return mc_hash[h] ? 3'd4 : 3'd0;
    if (a == station_addr) return 3'd2;
    return uc_hash[h] ? 3'd3 : 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bytes(input logic [47:0] a, input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      if (gaps && k > 0) begin
        int g = $urandom % 3;
        for (int j = 0; j < g; j++) begin
          @(negedge clk);
          byte_vld = 1'b0; sof = 1'b0;
        end
      end
      @(negedge clk);
      byte_vld = 1'b1;
      sof = (k == 0);
      byte_in = a[8*k +: 8];
    end
  endtask

  task automatic run_frame(input logic [47:0] a, input bit gaps, input string extra);
    logic [2:0] em = exp_match(a);
    string t = (extra != "") ? extra : tag_of(em);
    send_bytes(a, 6, gaps);
    @(negedge clk);
    byte_vld = 1'b0; sof = 1'b0;
    check("R1 valid", int'(dec_valid), 1);
    check({t, " match"}, int'(dec_match), int'(em));
    check({t, " accept"}, int'(dec_accept), int'(em != 3'd0));
    @(negedge clk);
    check("R1 pulse end", int'(dec_valid), 0);
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      byte_vld = 1'b0; sof = 1'b0; frm_end = 1'b0;
      seen += int'(dec_valid);
    end
    check(req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd1234));
    station_addr = 48'h5A_34_12_9C_3E_02;
    repeat (3) @(negedge clk);
    check("R11 reset valid", int'(dec_valid), 0);
    check("R11 reset accept", int'(dec_accept), 0);
    check("R11 reset match", int'(dec_match), 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_frame(station_addr, 0, "R4");
    run_frame({48{1'b1}}, 0, "R3");
    bcast_reject = 1'b1; uc_hash = '1; mc_hash = '1;
    run_frame({48{1'b1}}, 0, "R3");
    bcast_reject = 1'b0;
    mc_hash = '0;
    run_frame(station_addr | 48'h1, 0, "R2");
    uc_hash = '1;
    run_frame(station_addr ^ 48'h0100, 1, "R5");
    uc_hash = '0;
    run_frame(station_addr ^ 48'h0100, 1, "R8");
    promisc_en = 1'b1;
    run_frame(48'h0000_0000_1235, 0, "R7");
    promisc_en = 1'b0;

    // R9: restart mid-address
    send_bytes(48'hFFFF_FFFF_FFFF, 3, 0);
    run_frame(station_addr, 0, "R9");

    // R10: early frame end then no decision
    send_bytes(station_addr, 4, 0);
    @(negedge clk);
    byte_vld = 1'b0; sof = 1'b0; frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    byte_vld = 1'b1; byte_in = station_addr[39:32];
    @(negedge clk);
    byte_in = station_addr[47:40];
    quiet_window("R10 early end", 8);

    // R10: trailing bytes after the sixth
    run_frame(station_addr, 0, "R4");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      byte_vld = 1'b1; sof = 1'b0; byte_in = 8'(k);
    end
    quiet_window("R10 trailing", 4);

    // constrained random frames
    for (int f = 0; f < 300; f++) begin
      if (f % 8 == 0) begin
        uc_hash = {$urandom, $urandom};
        mc_hash = {$urandom, $urandom};
        bcast_reject = 1'($urandom % 2);
        promisc_en = ($urandom % 8 == 0);
      end
      a = {$urandom, $urandom};
      case ($urandom % 6)
        0: ;
        1: a = station_addr;
        2: a = {48{1'b1}};
        3: a[0] = 1'b1;
        4: a[0] = 1'b0;
        default: a = station_addr ^ (48'h1 << (1 + $urandom % 47));
      endcase
      run_frame(a, 1'($urandom % 2), "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule